// File: doc/BRIEF.md
# Directory Sharer-Tracking Controller

This block is the coherence directory that sits beside an inclusive shared last-level cache. It serves a small group of private caches (four by default). Because the shared cache is inclusive, every line that a private cache holds has an entry here. Each entry records which private caches hold a copy of the line. It also records whether one of those caches owns the line with write permission. Private caches send three kinds of request: read, read-for-ownership, and shared-cache eviction. For each request the directory sends coherence messages only to the caches that its holder list names. It then collects one acknowledgement from each of those caches, commits the updated entry, and reports that the request is complete.

The directory orders every request to a line. It takes one request at a time and holds `req_ready` low from the moment it accepts a request until that request completes, so a second request to any line waits. Data movement, transport and the private caches are outside this block. A message here carries only a kind and a set of destinations, and the cache that receives it answers with a single acknowledgement pulse.

Top module: `dir_sharer_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `msg_valid` and `done_valid` are 0, and every line entry is empty: no holders and no owner.
- R2: A read (`req_op` = 0) to a line that has no owner, or whose owner is the requester, sends no message. It completes with `done_valid` in the cycle after acceptance and adds the requester to the holders. An owner that reads its own line keeps ownership.
- R3: A read to a line owned by another cache sends one fetch message (`msg_kind` = 1) to that owner only. Afterwards the line has no owner, and both the former owner and the requester are holders.
- R4: A read-for-ownership (`req_op` = 1) sends an invalidate (`msg_kind` = 0) to every holder except the requester, and never to the requester. Afterwards the requester is the only holder and is the owner.
- R5: A shared-cache eviction (`req_op` = 2 or 3) sends an invalidate to every holder of the line, then leaves the entry empty.
- R6: All messages of one request appear together for exactly one cycle on `msg_valid`, where bit i addresses cache i. No message appears while the directory is idle.
- R7: A request completes only after every addressed cache has acknowledged on `ack_valid` (bit i from cache i). An acknowledgement from a cache that was not addressed has no effect.
- R8: Requests are serialized. `req_ready` is 0 from the cycle after acceptance through the completion cycle, and `done_valid` is a single-cycle pulse that carries the op, requester and line of the request.
- R9: The entry always keeps a single writer: a line that has an owner has exactly one holder, and that holder is the owner.
- R10: Entries of different lines are independent. A request changes only the entry of its own line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory idle; a request is accepted when req_valid and req_ready are both 1 |
| req_op | input | 2 | 0 read, 1 read-for-ownership, 2 or 3 eviction |
| req_src | input | $clog2(NUM_CACHES) | Requesting cache |
| req_line | input | $clog2(NUM_LINES) | Line index |
| msg_valid | output | NUM_CACHES | One bit per destination cache |
| msg_kind | output | 1 | 0 invalidate, 1 fetch-and-downgrade |
| ack_valid | input | NUM_CACHES | Acknowledgement pulse from each cache |
| done_valid | output | 1 | Completion pulse |
| done_op | output | 2 | Op of the completed request |
| done_src | output | $clog2(NUM_CACHES) | Requester of the completed request |
| done_line | output | $clog2(NUM_LINES) | Line of the completed request |

## Verification
The assertions assume that caches acknowledge only messages they have actually received. They also assume that `req_valid` is driven from the clock domain of `clk` and that `req_src` always names an existing cache. The stimulus keeps to these rules: the bench acknowledges only the bits it saw on `msg_valid`, with one exception. In one directed test it sends a stray acknowledgement from a cache that was not addressed, to check that the directory ignores it. That stray pulse never comes from a cache that still has an acknowledgement pending. The bench raises requests only while `req_ready` is high and only uses source numbers below the cache count.

// File: rtl/dir_pkg.sv
// Package: shared encodings for the directory controller.
// Assumes: op and message-kind codes are fixed by the block's port contract.
package dir_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_READX  = 2'd1,
        OP_EVICT  = 2'd2,
        OP_EVICT2 = 2'd3
    } dir_op_e;

    typedef enum logic {
        MSG_INVAL = 1'b0,
        MSG_FETCH = 1'b1
    } dir_msg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_COMMIT = 2'd3
    } dir_state_e;

endpackage

// File: rtl/dir_table.sv
// Module: per-line directory storage (holder vector, owner flag, owner id).
// Assumes: one combinational read port and one write port; reset empties all lines.
module dir_table #(
    parameter int NUM_CACHES = 4,
    parameter int NUM_LINES  = 16,
    localparam int SRC_W = $clog2(NUM_CACHES),
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_line,
    output logic [NUM_CACHES-1:0] rd_holders,
    output logic                  rd_owned,
    output logic [SRC_W-1:0]      rd_owner,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_line,
    input  logic [NUM_CACHES-1:0] wr_holders,
    input  logic                  wr_owned,
    input  logic [SRC_W-1:0]      wr_owner
);

    logic [NUM_CACHES-1:0] holders_q [NUM_LINES];
    logic                  owned_q   [NUM_LINES];
    logic [SRC_W-1:0]      owner_q   [NUM_LINES];

    // Clear all entries on reset, otherwise write the committed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                holders_q[i] <= '0;
                owned_q[i]   <= 1'b0;
                owner_q[i]   <= '0;
            end
        end else if (wr_en) begin
            holders_q[wr_line] <= wr_holders;
            owned_q[wr_line]   <= wr_owned;
            owner_q[wr_line]   <= wr_owner;
        end
    end

    // Present the addressed entry.
    always_comb begin
        rd_holders = holders_q[rd_line];
        rd_owned   = owned_q[rd_line];
        rd_owner   = owner_q[rd_line];
    end

endmodule

// File: rtl/dir_plan.sv
// Module: decides message targets, message kind and the next entry for a request.
// Assumes: purely combinational; the entry passed in is the current one for the line.
module dir_plan
    import dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    localparam int SRC_W = $clog2(NUM_CACHES)
) (
    input  dir_op_e               op,
    input  logic [SRC_W-1:0]      src,
    input  logic [NUM_CACHES-1:0] cur_holders,
    input  logic                  cur_owned,
    input  logic [SRC_W-1:0]      cur_owner,
    output logic [NUM_CACHES-1:0] targets,
    output dir_msg_e              kind,
    output logic [NUM_CACHES-1:0] nxt_holders,
    output logic                  nxt_owned,
    output logic [SRC_W-1:0]      nxt_owner
);

    logic [NUM_CACHES-1:0] src_bit;
    logic [NUM_CACHES-1:0] owner_bit;

    // One-hot forms of the requester and the current owner.
    always_comb begin
        src_bit   = '0;
        owner_bit = '0;
        src_bit[src]         = 1'b1;
        owner_bit[cur_owner] = 1'b1;
    end

    // Per-op selection of targets and resulting entry.
    always_comb begin
        targets     = '0;
        kind        = MSG_INVAL;
        nxt_holders = cur_holders;
        nxt_owned   = cur_owned;
        nxt_owner   = cur_owner;
        case (op)
            OP_READ: begin
                nxt_holders = cur_holders | src_bit;
                if (cur_owned && (cur_owner != src)) begin
                    targets   = owner_bit;
                    kind      = MSG_FETCH;
                    nxt_owned = 1'b0;
                end
            end
            OP_READX: begin
                targets     = cur_holders & ~src_bit;
                nxt_holders = src_bit;
                nxt_owned   = 1'b1;
                nxt_owner   = src;
            end
            default: begin
                targets     = cur_holders;
                nxt_holders = '0;
                nxt_owned   = 1'b0;
                nxt_owner   = '0;
            end
        endcase
    end

endmodule

// File: rtl/dir_ack_tracker.sv
// Module: tracks which addressed caches still owe an acknowledgement.
// Assumes: load happens only when a request is accepted; acks from unaddressed caches clear nothing.
module dir_ack_tracker #(
    parameter int NUM_CACHES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NUM_CACHES-1:0] load_mask,
    input  logic [NUM_CACHES-1:0] ack,
    output logic [NUM_CACHES-1:0] pending,
    output logic                  clear_next
);

    logic [NUM_CACHES-1:0] pending_next;

    // Remove acknowledged caches from the outstanding set.
    always_comb begin
        pending_next = pending & ~ack;
        clear_next   = (pending_next == '0);
    end

    // Hold the outstanding set across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else if (load)
            pending <= load_mask;
        else
            pending <= pending_next;
    end

endmodule

// File: rtl/dir_sharer_ctrl.sv
// Module: directory controller top. Accepts one request at a time, sends messages to
// listed holders, collects acks, commits the new entry and pulses completion.
// Assumes: ack bits arrive only for caches that received a message of this request.
module dir_sharer_ctrl
    import dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_LINES  = 16,
    localparam int SRC_W = $clog2(NUM_CACHES),
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_op,
    input  logic [SRC_W-1:0]      req_src,
    input  logic [IDX_W-1:0]      req_line,
    output logic [NUM_CACHES-1:0] msg_valid,
    output logic                  msg_kind,
    input  logic [NUM_CACHES-1:0] ack_valid,
    output logic                  done_valid,
    output logic [1:0]            done_op,
    output logic [SRC_W-1:0]      done_src,
    output logic [IDX_W-1:0]      done_line
);

    dir_state_e            state_q;
    dir_op_e               cur_op;
    logic [SRC_W-1:0]      cur_src;
    logic [IDX_W-1:0]      cur_line;
    dir_msg_e              cur_kind;
    logic [NUM_CACHES-1:0] cur_targets;
    logic [NUM_CACHES-1:0] cur_holders_n;
    logic                  cur_owned_n;
    logic [SRC_W-1:0]      cur_owner_n;

    logic [NUM_CACHES-1:0] rd_holders;
    logic                  rd_owned;
    logic [SRC_W-1:0]      rd_owner;
    logic [NUM_CACHES-1:0] pl_targets;
    dir_msg_e              pl_kind;
    logic [NUM_CACHES-1:0] pl_holders;
    logic                  pl_owned;
    logic [SRC_W-1:0]      pl_owner;
    logic [NUM_CACHES-1:0] pending;
    logic                  clear_next;
    logic                  accept;
    logic                  wr_en;

    assign accept = req_valid && req_ready;
    assign wr_en  = (state_q == ST_COMMIT);

    dir_table #(.NUM_CACHES(NUM_CACHES), .NUM_LINES(NUM_LINES)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_line    (req_line),
        .rd_holders (rd_holders),
        .rd_owned   (rd_owned),
        .rd_owner   (rd_owner),
        .wr_en      (wr_en),
        .wr_line    (cur_line),
        .wr_holders (cur_holders_n),
        .wr_owned   (cur_owned_n),
        .wr_owner   (cur_owner_n)
    );

    dir_plan #(.NUM_CACHES(NUM_CACHES)) i_plan (
        .op          (dir_op_e'(req_op)),
        .src         (req_src),
        .cur_holders (rd_holders),
        .cur_owned   (rd_owned),
        .cur_owner   (rd_owner),
        .targets     (pl_targets),
        .kind        (pl_kind),
        .nxt_holders (pl_holders),
        .nxt_owned   (pl_owned),
        .nxt_owner   (pl_owner)
    );

    dir_ack_tracker #(.NUM_CACHES(NUM_CACHES)) i_acks (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_mask  (pl_targets),
        .ack        (ack_valid),
        .pending    (pending),
        .clear_next (clear_next)
    );

    // Sequence one transaction: idle, send, wait for acks, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:   if (accept) state_q <= (pl_targets == '0) ? ST_COMMIT : ST_SEND;
                ST_SEND:   state_q <= clear_next ? ST_COMMIT : ST_WAIT;
                ST_WAIT:   if (clear_next) state_q <= ST_COMMIT;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request and its planned outcome at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op        <= OP_READ;
            cur_src       <= '0;
            cur_line      <= '0;
            cur_kind      <= MSG_INVAL;
            cur_targets   <= '0;
            cur_holders_n <= '0;
            cur_owned_n   <= 1'b0;
            cur_owner_n   <= '0;
        end else if (accept) begin
            cur_op        <= dir_op_e'(req_op);
            cur_src       <= req_src;
            cur_line      <= req_line;
            cur_kind      <= pl_kind;
            cur_targets   <= pl_targets;
            cur_holders_n <= pl_holders;
            cur_owned_n   <= pl_owned;
            cur_owner_n   <= pl_owner;
        end
    end

    // Drive the port-side view of the current state.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        msg_valid  = (state_q == ST_SEND) ? cur_targets : '0;
        msg_kind   = cur_kind;
        done_valid = (state_q == ST_COMMIT);
        done_op    = cur_op;
        done_src   = cur_src;
        done_line  = cur_line;
    end

endmodule

// File: rtl/dir_sharer_checker.sv
// Module: property checker for dir_sharer_ctrl, attached by bind.
// Assumes: observes ports plus the commit-side entry and the ack tracker state.
module dir_sharer_checker #(
    parameter int NUM_CACHES = 4,
    localparam int SRC_W = $clog2(NUM_CACHES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_ready,
    input logic [NUM_CACHES-1:0] msg_valid,
    input logic                  done_valid,
    input logic [1:0]            done_op,
    input logic [SRC_W-1:0]      done_src,
    input logic [NUM_CACHES-1:0] pending,
    input logic                  wr_en,
    input logic [NUM_CACHES-1:0] wr_holders,
    input logic                  wr_owned,
    input logic [SRC_W-1:0]      wr_owner
);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid != '0) |-> !req_ready);

    assert_msg_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid != '0) |=> (msg_valid == '0));

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !req_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_acks_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (pending == '0));

    assert_single_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_owned) |-> (($countones(wr_holders) == 1) && wr_holders[wr_owner]));

    assert_no_self_inval_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((msg_valid != '0) && (done_op == 2'd1)) |-> !msg_valid[done_src]);

    assert_excl_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (done_op == 2'd1)) |-> (wr_owned && (wr_owner == done_src)));

endmodule

bind dir_sharer_ctrl dir_sharer_checker #(.NUM_CACHES(NUM_CACHES)) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .msg_valid  (msg_valid),
    .done_valid (done_valid),
    .done_op    (done_op),
    .done_src   (done_src),
    .pending    (pending),
    .wr_en      (wr_en),
    .wr_holders (cur_holders_n),
    .wr_owned   (cur_owned_n),
    .wr_owner   (cur_owner_n)
);

// File: tb/test_dir_sharer_ctrl.sv
// Bench: vector table of requests with expected messages, then directed tests.
module test_dir_sharer_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NL = 16;
    localparam int NV = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = '0;
    logic [1:0] req_src = '0;
    logic [3:0] req_line = '0;
    logic [3:0] msg_valid;
    logic       msg_kind;
    logic [3:0] ack_valid = '0;
    logic       done_valid;
    logic [1:0] done_op;
    logic [1:0] done_src;
    logic [3:0] done_line;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_sharer_ctrl #(.NUM_CACHES(NC), .NUM_LINES(NL)) i_dir_sharer_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_src(req_src), .req_line(req_line),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .ack_valid(ack_valid),
        .done_valid(done_valid), .done_op(done_op), .done_src(done_src), .done_line(done_line)
    );

    // Vector: {op[2], src[2], line[4], exp_msg[4], exp_kind[1]} = 13 bits.
    localparam logic [12:0] VEC [NV] = '{
        {2'd0, 2'd0, 4'd1, 4'b0000, 1'b0},  // R2 read, empty line
        {2'd0, 2'd2, 4'd1, 4'b0000, 1'b0},  // R2 second reader
        {2'd1, 2'd2, 4'd1, 4'b0001, 1'b0},  // R4 invalidate other reader
        {2'd0, 2'd1, 4'd1, 4'b0100, 1'b1},  // R3 fetch from owner 2
        {2'd1, 2'd1, 4'd1, 4'b0100, 1'b0},  // R4 invalidate former owner
        {2'd1, 2'd1, 4'd1, 4'b0000, 1'b0},  // R4 owner re-requests, no message
        {2'd0, 2'd1, 4'd1, 4'b0000, 1'b0},  // R2 owner reads own line
        {2'd0, 2'd3, 4'd1, 4'b0010, 1'b1},  // R3 owner kept by previous read
        {2'd2, 2'd0, 4'd1, 4'b1010, 1'b0},  // R5 evict both holders
        {2'd2, 2'd0, 4'd1, 4'b0000, 1'b0},  // R5 entry emptied
        {2'd1, 2'd3, 4'd5, 4'b0000, 1'b0},  // R10 other line
        {2'd0, 2'd0, 4'd1, 4'b0000, 1'b0},  // R10 line 1 has no owner
        {2'd0, 2'd0, 4'd5, 4'b1000, 1'b1},  // R10 line 5 owner 3 intact
        {2'd3, 2'd3, 4'd5, 4'b1001, 1'b0}   // R5 op 3 evicts
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request, ack all messages at once, check messages and completion.
    task automatic run_req(input logic [1:0] op, input logic [1:0] src, input logic [3:0] line,
                           input logic [3:0] exp_msg, input logic exp_kind, input string req);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_src = src; req_line = line;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {req, " R8 busy"}, req_ready, 0);
        check(msg_valid == exp_msg, {req, " msg targets"}, msg_valid, exp_msg);
        if (exp_msg != 4'b0) begin
            check(msg_kind == exp_kind, {req, " msg kind"}, msg_kind, exp_kind);
            ack_valid = exp_msg;
            @(negedge clk);
            ack_valid = '0;
        end
        guard = 0;
        while (!done_valid && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        check(done_valid == 1'b1, {req, " R8 done"}, done_valid, 1);
        check({done_op, done_src, done_line} == {op, src, line}, {req, " R8 done fields"},
              {done_op, done_src, done_line}, {op, src, line});
        @(negedge clk);
        check(req_ready == 1'b1 && done_valid == 1'b0, {req, " R8 idle after"},
              {req_ready, done_valid}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(msg_valid == '0 && done_valid == 1'b0, "R1 quiet", {msg_valid, done_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(msg_valid == '0, "R6 idle no msg", msg_valid, 0);

        for (int i = 0; i < NV; i++) begin
            run_req(VEC[i][12:11], VEC[i][10:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0],
                    $sformatf("vec%0d", i));
        end

        // R7 staggered acks and ignored stray ack: build holders 0,1,2 on line 9, then 3 takes ownership.
        run_req(2'd0, 2'd0, 4'd9, 4'b0000, 1'b0, "R7 setup a");
        run_req(2'd0, 2'd1, 4'd9, 4'b0000, 1'b0, "R7 setup b");
        run_req(2'd0, 2'd2, 4'd9, 4'b0000, 1'b0, "R7 setup c");
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_src = 2'd3; req_line = 4'd9;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(msg_valid == 4'b0111 && msg_kind == 1'b0, "R4 R6 three invalidates",
              {msg_valid, msg_kind}, {4'b0111, 1'b0});
        ack_valid = 4'b1001;  // cache 0 real, cache 3 stray
        @(negedge clk);
        ack_valid = '0;
        check(msg_valid == '0, "R6 single-cycle messages", msg_valid, 0);
        repeat (3) @(negedge clk);
        check(done_valid == 1'b0 && req_ready == 1'b0, "R7 waits, stray ignored",
              {done_valid, req_ready}, 0);
        ack_valid = 4'b0010;
        @(negedge clk);
        ack_valid = '0;
        repeat (2) @(negedge clk);
        check(done_valid == 1'b0, "R7 still waits for cache 2", done_valid, 0);
        ack_valid = 4'b0100;
        @(negedge clk);
        ack_valid = '0;
        check(done_valid == 1'b1, "R7 done after last ack", done_valid, 1);
        @(negedge clk);
        // R9 sole holder: eviction must address only cache 3
        run_req(2'd2, 2'd0, 4'd9, 4'b1000, 1'b0, "R9 sole holder");

        // R1 reset empties entries
        run_req(2'd1, 2'd2, 4'd7, 4'b0000, 1'b0, "R1 pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_req(2'd2, 2'd0, 4'd7, 4'b0000, 1'b0, "R1 entry empty after reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule